// File: doc/BRIEF.md
# MFM Bit-Cell Encoder

This block turns a serial stream of data bits into the cell pattern that a modified-frequency-modulation recording channel writes. Each accepted bit becomes two cells: a clock cell, then a data cell. A cell is a pulse or the absence of one. A 1 always puts its pulse in the data cell. A 0 puts a pulse in its clock cell only when the bit before it was also 0. Pulses therefore never sit next to a 1, and a long run of zeros still carries clock pulses for the read side to lock onto.

Bits arrive on a valid/ready handshake. The encoder remembers the last bit it accepted, so it can decide the next clock cell. Cells leave one after another on a single output line. Each cell lasts `CELL_CYCLES` clock cycles, and a strobe marks the first cycle of each cell. When the upstream side supplies bits without pause, the cells form an unbroken train. A synchronous reset drops any cells still in flight and sets the remembered bit to 1, so a leading 0 gets no clock pulse.

Top module: `mfm_encoder`

## Requirements
- R1: Each accepted bit yields exactly two cells, the clock cell first and the data cell second. Each cell lasts `CELL_CYCLES` cycles. `cell_stb` is high only in the first cycle of each cell, and the clock cell's strobe appears in the cycle right after the handshake.
- R2: The data cell is 1 when the bit is 1 and 0 when the bit is 0.
- R3: The clock cell of a 1 is always 0.
- R4: The clock cell of a 0 is 0 when the bit accepted before it was 1.
- R5: The clock cell of a 0 is 1 when the bit accepted before it was 0. This holds even when idle cycles separate the two bits.
- R6: After reset the remembered previous bit is 1, so a 0 sent first gives a clock cell of 0.
- R7: `in_ready` is high when no cell is pending, and also in the last cycle of a data cell. It is low at all other times. Bits supplied back to back produce strobes exactly `CELL_CYCLES` cycles apart, with no gap.
- R8: When no cell is pending, `cell_out` is 0 and `cell_stb` is 0.
- R9: Reset discards any cells in flight. In the cycle after reset, `in_ready` is 1, `cell_out` is 0 and `cell_stb` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A data bit is offered |
| in_bit | input | 1 | The offered data bit |
| in_ready | output | 1 | The encoder takes the bit at this edge if `in_valid` is high |
| cell_out | output | 1 | Current cell level, 1 meaning a flux pulse |
| cell_stb | output | 1 | High in the first cycle of each cell |

## Verification
The assertions assume that `in_bit` is only meaningful while `in_valid` is high. They also assume a bit counts as taken only at an edge where both `in_valid` and `in_ready` are high. The bench changes its inputs only on falling edges and judges `in_ready` there, so a handshake never depends on the order of events at a rising edge. Every byte value is sent once as an unbroken stream, which keeps `in_ready` timing at its tightest. Shorter patterns are then sent with idle gaps between bits, which checks that the remembered bit survives while the line is idle.

// File: rtl/mfm_enc_pkg.sv
package mfm_enc_pkg;

    typedef struct packed {
        logic clk_cell;
        logic data_cell;
    } mfm_pair_t;

    typedef enum logic [1:0] {
        SLOTS_EMPTY = 2'd0,
        SLOT_DATA   = 2'd1,
        SLOT_CLOCK  = 2'd2
    } slot_e;

    localparam logic PREV_AFTER_RESET = 1'b1;

    // clock cell pulses only between two zeros; data cell mirrors the bit
    function automatic mfm_pair_t mfm_encode(input logic prev_bit, input logic cur_bit);
        mfm_pair_t p;
        p.clk_cell  = ~prev_bit & ~cur_bit;
        p.data_cell = cur_bit;
        return p;
    endfunction

endpackage

// File: rtl/mfm_cell_timer.sv
module mfm_cell_timer #(
    parameter int CELL_CYCLES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic busy,
    output logic cell_first,
    output logic cell_last
);
    localparam int CW = (CELL_CYCLES > 1) ? $clog2(CELL_CYCLES) : 1;

    generate
        if (CELL_CYCLES == 1) begin : g_single
            assign cell_first = 1'b1;
            assign cell_last  = 1'b1;
        end else begin : g_count
            localparam logic [CW-1:0] LAST_IDX = CW'(CELL_CYCLES - 1);
            logic [CW-1:0] pcnt;

            always_ff @(posedge clk) begin
                if (rst || restart) begin
                    pcnt <= '0;
                end else if (busy) begin
                    pcnt <= (pcnt == LAST_IDX) ? '0 : pcnt + 1'b1;
                end
            end

            assign cell_first = (pcnt == '0);
            assign cell_last  = (pcnt == LAST_IDX);

            // phase counter never leaves its range
            assert_phase_range_R1: assert property (@(posedge clk) disable iff (rst)
                pcnt <= LAST_IDX);
        end
    endgenerate

endmodule

// File: rtl/mfm_pair_shifter.sv
module mfm_pair_shifter
    import mfm_enc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load,
    input  mfm_pair_t pair_in,
    input  logic      cell_last,
    output logic      busy,
    output logic      take_ok,
    output logic      cell_level
);
    slot_e     slot;
    mfm_pair_t pair;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot <= SLOTS_EMPTY;
            pair <= '0;
        end else if (load) begin
            slot <= SLOT_CLOCK;
            pair <= pair_in;
        end else if (cell_last) begin
            case (slot)
                SLOT_CLOCK: slot <= SLOT_DATA;
                SLOT_DATA:  slot <= SLOTS_EMPTY;
                default:    slot <= SLOTS_EMPTY;
            endcase
        end
    end

    assign busy    = (slot != SLOTS_EMPTY);
    assign take_ok = (slot == SLOTS_EMPTY) || ((slot == SLOT_DATA) && cell_last);

    always_comb begin
        case (slot)
            SLOT_CLOCK: cell_level = pair.clk_cell;
            SLOT_DATA:  cell_level = pair.data_cell;
            default:    cell_level = 1'b0;
        endcase
    end

    assert_slot_legal_R1: assert property (@(posedge clk) disable iff (rst)
        slot != 2'd3);

    assert_clock_then_data_R1: assert property (@(posedge clk) disable iff (rst)
        (slot == SLOT_CLOCK && cell_last && !load) |=> (slot == SLOT_DATA));

    assert_no_load_midpair_R7: assert property (@(posedge clk) disable iff (rst)
        (slot == SLOT_CLOCK) |-> !load);

endmodule

// File: rtl/mfm_encoder.sv
module mfm_encoder
    import mfm_enc_pkg::*;
#(
    parameter int CELL_CYCLES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  logic in_bit,
    output logic in_ready,
    output logic cell_out,
    output logic cell_stb
);
    logic      prev_q;
    logic      load;
    logic      busy;
    logic      take_ok;
    logic      cell_first;
    logic      cell_last;
    mfm_pair_t next_pair;

    assign load      = in_valid && take_ok;
    assign next_pair = mfm_encode(prev_q, in_bit);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= PREV_AFTER_RESET;
        end else if (load) begin
            prev_q <= in_bit;
        end
    end

    mfm_cell_timer #(.CELL_CYCLES(CELL_CYCLES)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .restart    (load),
        .busy       (busy),
        .cell_first (cell_first),
        .cell_last  (cell_last)
    );

    mfm_pair_shifter u_shift (
        .clk        (clk),
        .rst        (rst),
        .load       (load),
        .pair_in    (next_pair),
        .cell_last  (cell_last),
        .busy       (busy),
        .take_ok    (take_ok),
        .cell_level (cell_out)
    );

    assign in_ready = take_ok;
    assign cell_stb = busy && cell_first;

    assert_stb_after_take_R1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> cell_stb);

    assert_one_no_clock_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && in_bit) |=> !cell_out);

    assert_zero_after_one_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && !in_bit && prev_q) |=> !cell_out);

    assert_zero_run_clock_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && !in_bit && !prev_q) |=> cell_out);

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!cell_out && !cell_stb));

    assert_idle_ready_R7: assert property (@(posedge clk) disable iff (rst)
        !busy |-> in_ready);

endmodule

// File: tb/sim_mfm_encoder.sv
module sim_mfm_encoder;
    localparam int CC = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic in_bit = 1'b0;
    logic in_ready, cell_out, cell_stb;

    int checks = 0;
    int errors = 0;
    int cycle = 0;
    int last_stb = -1;
    bit stream_mode = 1'b0;
    bit model_prev = 1'b1;
    bit exp_val[$];
    int exp_tag[$];

    always #5 clk = ~clk;

    mfm_encoder #(.CELL_CYCLES(CC)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_bit(in_bit),
        .in_ready(in_ready), .cell_out(cell_out), .cell_stb(cell_stb)
    );

    always @(posedge clk) cycle <= cycle + 1;

    function automatic string tag_name(input int t);
        case (t)
            2: return "R2 data cell";
            3: return "R3 clock cell of 1";
            4: return "R4 clock cell of 0 after 1";
            5: return "R5 clock cell of 0 after 0";
            6: return "R6 clock cell of first 0 after reset";
            default: return "R1";
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor: compare each strobed cell with the bench model
    always @(negedge clk) begin
        if (!rst && cell_stb) begin
            if (exp_val.size() == 0) begin
                check(1'b0, "R1 unexpected cell", 1, 0);
            end else begin
                check(cell_out == exp_val[0], tag_name(exp_tag[0]), cell_out, exp_val[0]);
                void'(exp_val.pop_front());
                void'(exp_tag.pop_front());
            end
            if (stream_mode && last_stb >= 0)
                check(cycle - last_stb == CC, "R7 strobe spacing", cycle - last_stb, CC);
            last_stb = cycle;
        end
    end

    task automatic send_bit(input bit b, input bit first_after_reset);
        bit r;
        @(negedge clk);
        in_valid = 1'b1;
        in_bit   = b;
        forever begin
            r = in_ready;
            @(posedge clk);
            if (r) break;
            @(negedge clk);
        end
        exp_val.push_back(!model_prev && !b);
        if (b)                   exp_tag.push_back(3);
        else if (first_after_reset) exp_tag.push_back(6);
        else if (model_prev)     exp_tag.push_back(4);
        else                     exp_tag.push_back(5);
        exp_val.push_back(b);
        exp_tag.push_back(2);
        model_prev = b;
    endtask

    task automatic go_idle(input int n);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic check_idle(input string req);
        check(cell_out == 1'b0, req, cell_out, 0);
        check(cell_stb == 1'b0, req, cell_stb, 0);
        check(in_ready == 1'b1, req, in_ready, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_idle("R9 reset state");

        // R6: leading zero after reset gets no clock pulse
        send_bit(1'b0, 1'b1);
        send_bit(1'b0, 1'b0);
        go_idle(2 * CC + 2);
        check_idle("R8 idle after pair");

        // R7: ready must drop during the clock cell
        @(negedge clk);
        in_valid = 1'b1; in_bit = 1'b1;
        @(negedge clk);
        check(in_ready == 1'b0, "R7 ready low in clock cell", in_ready, 0);
        model_prev = 1'b1;
        exp_val.push_back(1'b0); exp_tag.push_back(3);
        exp_val.push_back(1'b1); exp_tag.push_back(2);
        go_idle(2 * CC + 2);
        check_idle("R8 idle after single bit");

        // exhaustive byte sweep, back to back
        stream_mode = 1'b1;
        last_stb = -1;
        for (int v = 0; v < 256; v++)
            for (int i = 7; i >= 0; i--)
                send_bit(v[i], 1'b0);
        go_idle(2 * CC + 2);
        stream_mode = 1'b0;
        check_idle("R8 idle after sweep");
        check(exp_val.size() == 0, "R1 all cells emitted", exp_val.size(), 0);

        // gapped patterns: previous bit must survive idle time
        for (int v = 0; v < 64; v++)
            for (int i = 5; i >= 0; i--) begin
                send_bit(v[i], 1'b0);
                go_idle(v % 3 + ((i % 2) ? 2 * CC : 0));
            end
        go_idle(2 * CC + 2);
        check_idle("R8 idle after gapped patterns");

        // R9: reset mid-stream drops cells, then R6 again
        send_bit(1'b0, 1'b0);
        send_bit(1'b1, 1'b0);
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        exp_val.delete();
        exp_tag.delete();
        model_prev = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check_idle("R9 state after mid-stream reset");
        repeat (2 * CC) begin
            @(negedge clk);
            check(cell_stb == 1'b0, "R9 no stale cell", cell_stb, 0);
        end
        send_bit(1'b0, 1'b1);
        send_bit(1'b0, 1'b0);
        send_bit(1'b0, 1'b0);
        go_idle(2 * CC + 2);
        check(exp_val.size() == 0, "R1 all cells emitted at end", exp_val.size(), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1500000;
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycle, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule